// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with DMA Snoop Invalidation

This block sits between a processor's single-word load/store port and a 64K-word, word-addressed main memory. It keeps 128 lines of 16 words each (2K words in all), and each memory block has exactly one line it may occupy. Hits finish in the cycle they are presented. Misses stall the processor while a small sequencer moves whole lines over a request/acknowledge memory port.

Stores stay in the cache and mark their line dirty. Memory sees a modified line only when a later miss needs that slot. A DMA engine that writes main memory reports the 12-bit block number it touched. If that block is resident, its line is dropped at once, including while the line is being refilled, so the processor cannot read stale words.

Top module: `dm_cache`

## Requirements
- R1: A 16-bit word address splits, from the top bit down, into a 5-bit tag, a 7-bit line index and a 4-bit offset. Block n (address bits 15..4) may live only in line n mod 128. For example, 0x02EF maps to index 0x2E, tag 0, offset 0xF, and its miss fetches 0x02E0 through 0x02EF.
- R2: Reset clears every valid and dirty flag. In the first cycle after reset, cpu_ready and mem_req are low, and the first access misses without any memory write.
- R3: A read whose tag matches a valid line raises cpu_ready in the cycle it is presented, returns the cached word on cpu_rdata and makes no memory request.
- R4: A read miss on an invalid or clean line fetches the 16 words of the new block, with mem_we low, at {tag, index, offset} for offsets 0 to 15 in rising order. It then completes as a hit.
- R5: A write hit stores cpu_wdata in the cache only, with no memory write, and marks the line dirty.
- R6: A miss on a valid dirty line first writes its 16 words to {stored tag, index, offset} for offsets 0 to 15, with mem_we high. Only then does it fetch the new block.
- R7: A write miss allocates the line. The block is fetched, the written word is merged in, and the line becomes dirty.
- R8: A pulse on dma_wr with a block number equal to a valid line's {tag, index} clears that line's valid and dirty flags, so the next access to it misses. A block number that matches no resident line has no effect.
- R9: A DMA report for the block currently being fetched leaves that line invalid when the fetch ends. The stalled access then fetches the block again and returns the new memory contents.
- R10: cpu_ready stays low for the whole write-back and fetch sequence. With a memory that acknowledges each request one cycle after it appears, a clean miss completes 33 cycles after it is presented and a dirty miss 65 cycles after.
- R11: Once mem_req is raised, mem_addr, mem_we and mem_wdata hold steady until the cycle in which mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Store data |
| cpu_rdata | output | 16 | Load data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write-back word, 0 = fetch word |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Fetched word, valid with mem_ack |
| mem_ack | input | 1 | Memory accepts or answers the current request |
| dma_wr | input | 1 | DMA engine changed a word of block dma_blk |
| dma_blk | input | 12 | Block number (address bits 15..4) written by DMA |

## Verification
The assertions check several rules on every cycle. The processor never completes while memory is busy. A memory request holds steady until acknowledged. After reset the block is idle. A fetch walks its offsets in order. A write-back that ends is followed at once by a fetch of offset 0. A DMA hit on the block being accessed always forces that access to stall. Data correctness depends on history, so only the bench scenarios can show it. This covers words merged into allocated lines, dirty data reaching memory on eviction, the new memory contents returned after invalidation and after an aborted refill, and the exact stall lengths and memory traffic counts of each access type.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int TAG_W = 5,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             set_dirty,
    input  logic             fill_start,
    input  logic             fill_done,
    input  logic             fill_valid,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dma_wr,
    input  logic [IDX_W-1:0] dma_idx,
    input  logic [TAG_W-1:0] dma_tag
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0] valid;
        logic [LINES-1:0] dirty;
    } flags_t;

    flags_t            flg_d, flg_q;
    logic [TAG_W-1:0]  tag_d [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [LINES-1:0]  dma_drop;

    // One snoop comparator per line
    for (genvar g = 0; g < LINES; g++) begin : g_snoop
        assign dma_drop[g] = dma_wr && (dma_idx == IDX_W'(g))
                             && flg_q.valid[g] && (tag_q[g] == dma_tag);
    end

    always_comb begin
        flg_d = flg_q;
        tag_d = tag_q;
        if (fill_start) begin
            flg_d.valid[rd_idx] = 1'b0;
            flg_d.dirty[rd_idx] = 1'b0;
        end
        if (set_dirty) begin
            flg_d.dirty[rd_idx] = 1'b1;
        end
        flg_d.valid = flg_d.valid & ~dma_drop;
        flg_d.dirty = flg_d.dirty & ~dma_drop;
        if (fill_done) begin
            flg_d.valid[rd_idx] = fill_valid;
            flg_d.dirty[rd_idx] = 1'b0;
            tag_d[rd_idx]       = fill_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = flg_q.valid[rd_idx];
    assign rd_dirty = flg_q.dirty[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int IDX_W = 7,
    parameter int OFF_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [TAG_W-1:0]             cpu_tag,
    input  logic [IDX_W-1:0]             cpu_idx,
    input  logic                         hit,
    input  logic                         line_valid,
    input  logic                         line_dirty,
    input  logic [TAG_W-1:0]             line_tag,
    input  logic                         mem_ack,
    input  logic                         dma_wr,
    input  logic [TAG_W+IDX_W-1:0]       dma_blk,
    output logic                         cpu_ready,
    output logic                         set_dirty,
    output logic                         fill_start,
    output logic                         fill_done,
    output logic                         fill_valid,
    output logic                         fill_we,
    output logic [OFF_W-1:0]             beat,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr
);
    localparam logic [OFF_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        dmc_state_e       st;
        logic [OFF_W-1:0] beat;
        logic             kill;
    } ctl_t;

    ctl_t c_d, c_q;
    logic dma_same;

    assign dma_same = dma_wr && (dma_blk == {cpu_tag, cpu_idx});

    always_comb begin
        c_d        = c_q;
        cpu_ready  = 1'b0;
        set_dirty  = 1'b0;
        fill_start = 1'b0;
        fill_done  = 1'b0;
        fill_valid = 1'b0;
        fill_we    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {cpu_tag, cpu_idx, c_q.beat};
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                        set_dirty = cpu_we;
                    end else begin
                        c_d.beat = '0;
                        c_d.kill = 1'b0;
                        if (line_valid && line_dirty) begin
                            c_d.st = ST_EVICT;
                        end else begin
                            c_d.st     = ST_FILL;
                            fill_start = 1'b1;
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {line_tag, cpu_idx, c_q.beat};
                if (mem_ack) begin
                    c_d.beat = c_q.beat + OFF_W'(1);
                    if (c_q.beat == LAST_BEAT) begin
                        c_d.st     = ST_FILL;
                        fill_start = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (dma_same) begin
                    c_d.kill = 1'b1;
                end
                if (mem_ack) begin
                    fill_we  = 1'b1;
                    c_d.beat = c_q.beat + OFF_W'(1);
                    if (c_q.beat == LAST_BEAT) begin
                        fill_done  = 1'b1;
                        fill_valid = !(c_q.kill || dma_same);
                        c_d.st     = ST_IDLE;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, beat: '0, kill: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign beat = c_q.beat;
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic                         mem_ack,
    input  logic                         dma_wr,
    input  logic [TAG_W+IDX_W-1:0]       dma_blk
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
    localparam int LOC_W  = IDX_W + OFF_W;

    logic [TAG_W-1:0] cpu_tag, line_tag, dma_tag;
    logic [IDX_W-1:0] cpu_idx, dma_idx;
    logic [OFF_W-1:0] cpu_off, beat;
    logic             line_valid, line_dirty, hit;
    logic             set_dirty, fill_start, fill_done, fill_valid, fill_we;
    logic             dat_we;
    logic [LOC_W-1:0] dat_waddr;
    logic [DATA_W-1:0] dat_wdata;

    assign {cpu_tag, cpu_idx, cpu_off} = cpu_addr[ADDR_W-1:0];
    assign {dma_tag, dma_idx}          = dma_blk;

    dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (cpu_idx),
        .rd_tag     (line_tag),
        .rd_valid   (line_valid),
        .rd_dirty   (line_dirty),
        .set_dirty  (set_dirty),
        .fill_start (fill_start),
        .fill_done  (fill_done),
        .fill_valid (fill_valid),
        .fill_tag   (cpu_tag),
        .dma_wr     (dma_wr),
        .dma_idx    (dma_idx),
        .dma_tag    (dma_tag)
    );

    assign hit = line_valid && (line_tag == cpu_tag);

    dmc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_tag    (cpu_tag),
        .cpu_idx    (cpu_idx),
        .hit        (hit),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .mem_ack    (mem_ack),
        .dma_wr     (dma_wr),
        .dma_blk    (dma_blk),
        .cpu_ready  (cpu_ready),
        .set_dirty  (set_dirty),
        .fill_start (fill_start),
        .fill_done  (fill_done),
        .fill_valid (fill_valid),
        .fill_we    (fill_we),
        .beat       (beat),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    // Fetched words and store hits share the single write port
    always_comb begin
        dat_we    = fill_we || set_dirty;
        dat_waddr = fill_we ? {cpu_idx, beat} : {cpu_idx, cpu_off};
        dat_wdata = fill_we ? mem_rdata : cpu_wdata;
    end

    dmc_data_store #(.AW(LOC_W), .DW(DATA_W)) u_data (
        .clk     (clk),
        .we      (dat_we),
        .waddr   (dat_waddr),
        .wdata   (dat_wdata),
        .raddr_a ({cpu_idx, cpu_off}),
        .rdata_a (cpu_rdata),
        .raddr_b ({cpu_idx, beat}),
        .rdata_b (mem_wdata)
    );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cpu_req,
    input logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
    input logic                         cpu_ready,
    input logic                         mem_req,
    input logic                         mem_we,
    input logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    input logic [DATA_W-1:0]            mem_wdata,
    input logic                         mem_ack,
    input logic                         dma_wr,
    input logic [TAG_W+IDX_W-1:0]       dma_blk
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
    localparam logic [OFF_W-1:0] LAST = '1;

    // R10: processor never completes while a memory word is in flight
    p_ready_no_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req)
        else $error("p_ready_no_mem_r10");

    // R11: request fields hold until acknowledged
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)))
        else $error("p_mem_hold_r11");

    // R2: idle right after reset
    p_reset_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_ready && !mem_req))
        else $error("p_reset_idle_r2");

    // R4: fetch walks offsets upward within one block
    p_fill_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && mem_addr[OFF_W-1:0] != LAST)
        |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + 1'b1))
        else $error("p_fill_order_r4");

    // R6: last write-back word is followed by fetch of offset 0, same index
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && mem_addr[OFF_W-1:0] == LAST)
        |=> (mem_req && !mem_we && mem_addr[OFF_W-1:0] == '0
             && mem_addr[OFF_W+IDX_W-1:OFF_W] == $past(mem_addr[OFF_W+IDX_W-1:OFF_W])))
        else $error("p_wb_then_fill_r6");

    // R8 and R9: a snoop hit on the requested block forces a stall next cycle
    p_dma_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && cpu_req && dma_blk == cpu_addr[ADDR_W-1:OFF_W])
        |=> !(cpu_req && cpu_ready && $stable(cpu_addr)))
        else $error("p_dma_kill_r8");
endmodule

bind dm_cache dmc_checker #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .dma_wr    (dma_wr),
    .dma_blk   (dma_blk)
);

// File: tb/sim_dm_cache.sv
`timescale 1ns/1ps
module sim_dm_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        dma_wr = 1'b0;
    logic [11:0] dma_blk = '0;
    logic [15:0] dma_word = '0, dma_data = '0;

    always #2 clk = ~clk;

    dm_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .dma_wr(dma_wr), .dma_blk(dma_blk)
    );

    // ---------------- memory model: ack one cycle after request
    logic [15:0] wmem [logic [15:0]];
    logic [15:0] view [logic [15:0]];
    int          n_rd = 0, n_wr = 0, hs_err = 0;
    logic [15:0] last_rd = '0, last_wr = '0, held = '0;

    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5AA5;
    endfunction

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        return wmem.exists(a) ? wmem[a] : pat(a);
    endfunction

    function automatic logic [15:0] ref_rd(input logic [15:0] a);
        return view.exists(a) ? view[a] : pat(a);
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            held       = mem_addr;
            mem_rdata <= mem_rd(mem_addr);
            if (mem_we) begin
                wmem[mem_addr] = mem_wdata;
                n_wr++;
                last_wr = mem_addr;
            end else begin
                n_rd++;
                last_rd = mem_addr;
            end
        end else begin
            if (mem_ack && mem_addr != held) hs_err++;
            mem_ack <= 1'b0;
        end
        if (dma_wr) wmem[dma_word] = dma_data;
    end

    // ---------------- checking
    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [15:0] a, input logic [15:0] wd,
                        output logic [15:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) view[a] = wd;
    endtask

    task automatic dma(input logic [15:0] word, input logic [15:0] val);
        @(negedge clk);
        dma_wr = 1'b1; dma_blk = word[15:4]; dma_word = word; dma_data = val;
        view[word] = val;
        @(negedge clk);
        dma_wr = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [7:0]  cyc;
        logic [4:0]  nrd;
        logic [4:0]  nwr;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{1'b0, 16'h02EF, 16'h0000, 8'd33, 5'd16, 5'd0},
        '{1'b0, 16'h02E0, 16'h0000, 8'd0,  5'd0,  5'd0},
        '{1'b0, 16'h02E5, 16'h0000, 8'd0,  5'd0,  5'd0},
        '{1'b1, 16'h02E3, 16'h1234, 8'd0,  5'd0,  5'd0},
        '{1'b0, 16'h02E3, 16'h0000, 8'd0,  5'd0,  5'd0},
        '{1'b0, 16'h0AE3, 16'h0000, 8'd65, 5'd16, 5'd16},
        '{1'b0, 16'h02E3, 16'h0000, 8'd33, 5'd16, 5'd0},
        '{1'b1, 16'h4100, 16'hBEEF, 8'd33, 5'd16, 5'd0},
        '{1'b0, 16'h4100, 16'h0000, 8'd0,  5'd0,  5'd0},
        '{1'b0, 16'h410F, 16'h0000, 8'd0,  5'd0,  5'd0},
        '{1'b0, 16'h0100, 16'h0000, 8'd65, 5'd16, 5'd16},
        '{1'b0, 16'h4100, 16'h0000, 8'd33, 5'd16, 5'd0}
    };

    function automatic string kind(input vec_t v);
        if (v.cyc == 0) return v.we ? "R5" : "R3";
        if (v.nwr != 0) return "R6";
        return v.we ? "R7" : "R4";
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          cyc, rd0, wr0;
        vec_t        v;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2: idle outputs after reset
        chk(cpu_ready == 1'b0, "R2", "cpu_ready after reset", int'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R2", "mem_req after reset", int'(mem_req), 0);

        for (int i = 0; i < 12; i++) begin
            v   = TBL[i];
            rd0 = n_rd; wr0 = n_wr;
            xfer(v.we, v.addr, v.wdata, rd, cyc);
            chk(cyc == int'(v.cyc), "R10", {kind(v), " stall cycles"}, cyc, int'(v.cyc));
            chk(n_rd - rd0 == int'(v.nrd), kind(v), "memory reads", n_rd - rd0, int'(v.nrd));
            chk(n_wr - wr0 == int'(v.nwr), kind(v), "memory writes", n_wr - wr0, int'(v.nwr));
            if (!v.we)
                chk(rd == ref_rd(v.addr), kind(v), "read data", int'(rd), int'(ref_rd(v.addr)));
            if (i == 0) begin
                // R1 and R2: cold miss on 0x02EF fetches 0x02E0..0x02EF, no write-back
                chk(last_rd == 16'h02EF, "R1", "last fetch address", int'(last_rd), 16'h02EF);
                chk(n_wr == 0, "R2", "writes on first miss", n_wr, 0);
            end
            if (i == 5) begin
                // R6: dirty word reached memory at the old tag's address
                chk(mem_rd(16'h02E3) == 16'h1234, "R6", "written-back word",
                    int'(mem_rd(16'h02E3)), 16'h1234);
                chk(last_wr == 16'h02EF, "R6", "last write-back address", int'(last_wr), 16'h02EF);
            end
            if (i == 10)
                // R7: allocated store was marked dirty and written back
                chk(mem_rd(16'h4100) == 16'hBEEF, "R7", "merged word written back",
                    int'(mem_rd(16'h4100)), 16'hBEEF);
        end

        // R8: snoop hit invalidates the resident line (tag 8, index 0x10)
        dma(16'h4105, 16'h7777);
        xfer(1'b0, 16'h4105, 16'h0, rd, cyc);
        chk(cyc == 33, "R8", "miss after invalidate", cyc, 33);
        chk(rd == 16'h7777, "R8", "fresh data after invalidate", int'(rd), 16'h7777);

        // R8: snoop for a non-resident block of the same index has no effect
        dma(16'h0102, 16'h2222);
        xfer(1'b0, 16'h4100, 16'h0, rd, cyc);
        chk(cyc == 0, "R8", "still a hit after unrelated snoop", cyc, 0);
        chk(rd == ref_rd(16'h4100), "R8", "data unchanged", int'(rd), int'(ref_rd(16'h4100)));

        // R9: snoop of the block being fetched forces a second fetch
        rd0 = n_rd;
        @(negedge clk);
        fork
            xfer(1'b0, 16'h3F20, 16'h0, rd, cyc);
            begin
                repeat (10) @(negedge clk);
                dma(16'h3F20, 16'h9999);
            end
        join
        chk(cyc == 66, "R9", "stall with aborted fetch", cyc, 66);
        chk(n_rd - rd0 == 32, "R9", "words fetched", n_rd - rd0, 32);
        chk(rd == 16'h9999, "R9", "data after refetch", int'(rd), 16'h9999);

        // R11: memory saw steady request fields in every acknowledged cycle
        chk(hs_err == 0, "R11", "handshake address changes", hs_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule